// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a host that wants single-word reads and writes and an SDRAM device. The host hands over one request at a time, with a bank, row, column, write data and byte enables. The sequencer turns each request into a row activate followed by one column command with auto-precharge. It brings the device out of power-up and inserts auto refreshes on a fixed interval. When the host allows it, the sequencer parks the device in power-down between accesses. The tristate pads, PHY and memory array are outside the block. The block drives a data-output-enable and samples an input data bus.

Every device timing minimum is a parameter in nanoseconds. Each one is converted to whole clocks by dividing by the clock period and rounding up. The refresh interval comes from the retention window and the number of refresh commands per window. Requests use a valid/ready handshake. A request is taken on a cycle where both valid and ready are high. While valid is high and ready is low, the host must hold the request fields stable. Read data has no back-pressure: the host must accept the one-cycle read strobe when it comes.

Top module: `sdseq_top`

## Requirements
- R1: After reset, with CKE high and only NOPs before it, the sequencer waits the power-up delay. It then issues, in order: a precharge with address bit 10 high (all banks), two auto refreshes, and a mode load. The mode load carries address bits [6:4] equal to the CAS latency, bit 3 zero (sequential) and bits [2:0] zero (burst of one), with every other bit zero. Ready stays low until this sequence is finished.
- R2: A read or write comes no sooner than ceil(tRCD/period) clocks after the activate of its row.
- R3: An activate or refresh comes no sooner than ceil(tRC/period) clocks after the previous activate or refresh. It also waits for the bank to be closed: the auto-precharge starts at the later of (activate + tRAS) and burst end, or write recovery after a write, and then takes tRP.
- R4: Each request produces an activate with its bank and row, followed by a single read or write to the same bank. That command carries the column on the low address bits and address bit 10 high (auto-precharge). No explicit precharge is issued after initialization.
- R5: In the write command cycle, the output enable is high and the write data is driven. DQM equals the inverted byte enables, so a DQM bit high means that byte is left unchanged. A write with all enables low changes nothing.
- R6: DQM is all ones in the three cycles before every write command. DQM is all ones in every cycle that is neither a write cycle nor the read output-enable cycle. In the read output-enable cycle, which is CAS latency minus two cycles after the read command, DQM is all zeros.
- R7: Read valid pulses for one cycle, exactly CAS latency plus one cycles after the read command. It carries the word that was on the input data bus CAS latency cycles after that command.
- R8: Two auto refreshes issued after initialization are never more than the refresh interval plus one access time plus four clocks apart. A refresh that is due is issued before any waiting request, and ready is low while a refresh is pending.
- R9: Requests are accepted only on valid and ready together, and are executed in order of acceptance. The activate follows in the next cycle.
- R10: When power-down is allowed and the sequencer is idle with no pending refresh, CKE drops; CKE drops only when every bank is closed. While CKE is low only NOPs are driven. A request or a due refresh raises CKE, and CKE is high in the cycle before any activate or refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DATA_W | Write word |
| req_be | input | DATA_W/8 | Byte enables for a write (1 = write byte) |
| rd_valid | output | 1 | Read word valid strobe |
| rd_data | output | DATA_W | Read word |
| pd_en | input | 1 | Allow power-down while idle |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write strobe, low active |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row, column or mode word |
| sd_dqm | output | DATA_W/8 | Per-byte data mask |
| sd_dq_out | output | DATA_W | Write data toward the pads |
| sd_dq_oe | output | 1 | Drive enable for the data pads |
| sd_dq_in | input | DATA_W | Read data from the pads |

## Verification
The bench pushes a write followed at once by a read of the same word, to test whether DQM stays high ahead of the write. A design that dropped the mask too early would show up there. Power-down is held through a full refresh interval: a sequencer that forgot to wake for the refresh would break the refresh gap check. A sequencer that fired an activate in the cycle CKE rose would also be caught. A long back-to-back request stream checks that refreshes win over waiting requests. Partial and empty byte enables check that masked bytes read back unchanged. A read strobe that is one cycle early or late is checked by comparing against the word the bench placed on the bus only in the CAS-latency cycle.

// File: rtl/sdseq_pkg.sv
`timescale 1ns/1ps
package sdseq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_IPRE, ST_IREF, ST_IMRS, ST_IDLE,
    ST_PD, ST_WAKE, ST_RCD, ST_ACC, ST_REFW
  } seq_st_e;

  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdseq_refresh_timer.sv
`timescale 1ns/1ps
module sdseq_refresh_timer #(
  parameter int INTERVAL = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int W = $clog2(INTERVAL + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= W'(INTERVAL - 1);
      pend <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= W'(INTERVAL - 1);
      pend <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
      if (ack) pend <= 1'b0;
    end
  end

  // R8
  ack_when_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);
  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);
endmodule

// File: rtl/sdseq_rd_pipe.sv
`timescale 1ns/1ps
module sdseq_rd_pipe #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  output logic [DEPTH:1]   taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= {taps[DEPTH-1:1], strobe};
  end

  // R7
  single_read_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taps));
endmodule

// File: rtl/sdseq_top.sv
`timescale 1ns/1ps
module sdseq_top
  import sdseq_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int BANK_W        = 2,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 9,
  parameter int ADDR_W        = 13,
  parameter int CLK_NS        = 8,
  parameter int T_RP_NS       = 24,
  parameter int T_RCD_NS      = 24,
  parameter int T_RAS_NS      = 60,
  parameter int T_RC_NS       = 90,
  parameter int T_WR_CYC      = 2,
  parameter int T_MRD_CYC     = 2,
  parameter int CAS_LAT       = 2,
  parameter int POWERUP_CYC   = 12500,
  parameter int REF_WINDOW_NS = 64000000,
  parameter int REF_COUNT     = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [COL_W-1:0]      req_col,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  pd_en,
  output logic                  sd_cke,
  output logic                  sd_cs_n,
  output logic                  sd_ras_n,
  output logic                  sd_cas_n,
  output logic                  sd_we_n,
  output logic [BANK_W-1:0]     sd_ba,
  output logic [ADDR_W-1:0]     sd_addr,
  output logic [DATA_W/8-1:0]   sd_dqm,
  output logic [DATA_W-1:0]     sd_dq_out,
  output logic                  sd_dq_oe,
  input  logic [DATA_W-1:0]     sd_dq_in
);
  localparam int NB      = DATA_W / 8;
  localparam int TRP     = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int TRCD    = ns_to_cyc(T_RCD_NS, CLK_NS);
  localparam int TRAS    = ns_to_cyc(T_RAS_NS, CLK_NS);
  localparam int TRC     = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int ACC_CYC = imax(imax(TRC, TRAS + TRP),
                                imax(TRCD + T_WR_CYC + TRP, TRCD + CAS_LAT + 2));
  localparam int REFI    = REF_WINDOW_NS / REF_COUNT / CLK_NS;
  localparam int CNT_W   = $clog2(imax(POWERUP_CYC, ACC_CYC) + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'({3'(CAS_LAT), 4'b0000});

  seq_st_e              state;
  sd_cmd_e              cmd_q;
  logic [CNT_W-1:0]     cnt;
  logic                 cke_q, iref_two, wr_cyc, oe_q, rd_valid_q;
  logic [NB-1:0]        wmask_q;
  logic [DATA_W-1:0]    dq_q, rd_data_q;
  logic [BANK_W-1:0]    ba_q;
  logic [ADDR_W-1:0]    addr_q, row_word, col_word;
  logic                 acc_we;
  logic [BANK_W-1:0]    acc_bank;
  logic [ROW_W-1:0]     acc_row;
  logic [COL_W-1:0]     acc_col;
  logic [DATA_W-1:0]    acc_data;
  logic [NB-1:0]        acc_be;
  logic                 ref_pend, ref_ack, rd_issue;
  logic [CAS_LAT+1:1]   rd_taps;

  sdseq_refresh_timer #(.INTERVAL(REFI)) u_refresh (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend));

  sdseq_rd_pipe #(.DEPTH(CAS_LAT + 1)) u_rd_pipe (
    .clk(clk), .rst_n(rst_n), .strobe(rd_issue), .taps(rd_taps));

  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign ref_ack   = (state == ST_IDLE) && ref_pend;
  assign rd_issue  = (state == ST_RCD) && (cnt == '0) && !acc_we;

  always_comb begin
    row_word = '0;
    row_word[ROW_W-1:0] = acc_row;
    col_word = '0;
    col_word[COL_W-1:0] = acc_col;
    col_word[10] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_PWR; cmd_q <= CMD_NOP; cnt <= CNT_W'(POWERUP_CYC - 1);
      cke_q <= 1'b1; iref_two <= 1'b0; wr_cyc <= 1'b0; oe_q <= 1'b0;
      wmask_q <= '1; dq_q <= '0; ba_q <= '0; addr_q <= '0;
      acc_we <= 1'b0; acc_bank <= '0; acc_row <= '0; acc_col <= '0;
      acc_data <= '0; acc_be <= '0;
    end else begin
      cmd_q  <= CMD_NOP;
      wr_cyc <= 1'b0;
      oe_q   <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (state)
        ST_PWR: if (cnt == '0) begin
          cmd_q <= CMD_PRE; addr_q <= ADDR_W'(1 << 10);
          cnt <= CNT_W'(TRP - 1); state <= ST_IPRE;
        end
        ST_IPRE: if (cnt == '0) begin
          cmd_q <= CMD_REF; cnt <= CNT_W'(TRC - 1); state <= ST_IREF;
        end
        ST_IREF: if (cnt == '0) begin
          if (!iref_two) begin
            cmd_q <= CMD_REF; iref_two <= 1'b1; cnt <= CNT_W'(TRC - 1);
          end else begin
            cmd_q <= CMD_MRS; addr_q <= MODE_WORD; ba_q <= '0;
            cnt <= CNT_W'(T_MRD_CYC - 1); state <= ST_IMRS;
          end
        end
        ST_IMRS: if (cnt == '0) state <= ST_IDLE;
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_q <= CMD_REF; cnt <= CNT_W'(TRC - 1); state <= ST_REFW;
          end else if (req_valid) begin
            acc_we <= req_we; acc_bank <= req_bank; acc_row <= req_row;
            acc_col <= req_col; acc_data <= req_wdata; acc_be <= req_be;
            cmd_q <= CMD_ACT; ba_q <= req_bank;
            addr_q <= ADDR_W'(req_row);
            cnt <= CNT_W'(TRCD - 1); state <= ST_RCD;
          end else if (pd_en) begin
            cke_q <= 1'b0; state <= ST_PD;
          end
        end
        ST_PD: if (ref_pend || req_valid) begin
          cke_q <= 1'b1; state <= ST_WAKE;
        end
        ST_WAKE: state <= ST_IDLE;
        ST_RCD: if (cnt == '0) begin
          ba_q <= acc_bank; addr_q <= col_word;
          cnt <= CNT_W'(ACC_CYC - TRCD - 1); state <= ST_ACC;
          if (acc_we) begin
            cmd_q <= CMD_WR; wr_cyc <= 1'b1; oe_q <= 1'b1;
            dq_q <= acc_data; wmask_q <= ~acc_be;
          end else begin
            cmd_q <= CMD_RD;
          end
        end
        ST_ACC:  if (cnt == '0) state <= ST_IDLE;
        ST_REFW: if (cnt == '0) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0; rd_data_q <= '0;
    end else begin
      rd_valid_q <= rd_taps[CAS_LAT+1];
      if (rd_taps[CAS_LAT+1]) rd_data_q <= sd_dq_in;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke    = cke_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
  assign sd_dqm    = wr_cyc ? wmask_q : (rd_taps[CAS_LAT-1] ? '0 : '1);
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;

  // R10
  pd_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> (cmd_q == CMD_NOP));
  // R10
  cke_before_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> $past(sd_cke));
  // R6
  wr_mask_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WR) |-> (&$past(sd_dqm, 1) && &$past(sd_dqm, 2) && &$past(sd_dqm, 3)));
  // R8
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && ref_pend) |=> (cmd_q == CMD_REF));
  // R9
  accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_q == CMD_ACT && sd_ba == $past(req_bank)));
endmodule

// File: tb/sdseq_top_test.sv
`timescale 1ns/1ps
module sdseq_top_test;
  localparam int CL = 2, PER = 8, POW = 20, TWR = 2;
  localparam int REFWIN = 300 * PER * 4096;
  localparam int TRP = (24 + PER - 1) / PER, TRCD = (24 + PER - 1) / PER;
  localparam int TRAS = (60 + PER - 1) / PER, TRC = (90 + PER - 1) / PER;
  localparam int REFI = REFWIN / 4096 / PER;
  localparam int REF_LIMIT = REFI + 12 + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, pd_en = 1'b0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic [31:0] req_wdata = '0, sd_dq_in = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [31:0] rd_data, sd_dq_out;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;
  logic [3:0] sd_dqm;

  sdseq_top #(.CLK_NS(PER), .POWERUP_CYC(POW), .REF_WINDOW_NS(REFWIN), .CAS_LAT(CL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .pd_en(pd_en), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  always #4 clk = ~clk;

  typedef struct { bit we; int bank; int row; int col; logic [31:0] data; logic [3:0] be; } req_s;
  req_s acc_q[$];
  logic [31:0] mem [int];
  int compared = 0, mismatched = 0, cyc = 0, rel_cyc = 0;
  int init_step = 0, last_act = -1000, last_ref = -1000, last_rd = -1000, act_cyc = 0;
  int bank_free = 0, pd_cycles = 0, refs_after = 0, reads_seen = 0;
  bit open_row = 0, cke_prev = 1;
  logic [3:0] dqm_h1 = '1, dqm_h2 = '1, dqm_h3 = '1;
  logic [31:0] rd_word = '0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int key_of(input int b, input int r, input int c);
    return b * (1 << 21) + r * (1 << 9) + c;
  endfunction

  function automatic logic [31:0] word_at(input int k);
    if (mem.exists(k)) return mem[k];
    return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // Behavioural device model and protocol reference, compared every clock
  always @(negedge clk) begin
    logic [3:0] cmd, exp_dqm;
    int ps, k;
    req_s r;
    if (rst_n) begin
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!sd_cke) begin
        pd_cycles++;
        chk(cmd == 4'b0111, "R10 only NOP with CKE low", cmd, 4'b0111);
        if (cke_prev) chk(!open_row && cyc >= bank_free, "R10 power-down with banks closed", cyc, bank_free);
      end else begin
        if (init_step < 4 && cmd != 4'b0111) begin
          case (init_step)
            0: begin chk(cmd == 4'b0010 && sd_addr[10], "R1 first command precharge-all", cmd, 4'b0010);
                      chk(cyc - rel_cyc >= POW, "R1 power-up wait", cyc - rel_cyc, POW); end
            1, 2: chk(cmd == 4'b0001, "R1 init refresh", cmd, 4'b0001);
            default: begin chk(cmd == 4'b0000, "R1 mode load", cmd, 4'b0000);
                      chk(sd_addr == 13'(CL << 4), "R1 mode word", sd_addr, CL << 4); end
          endcase
          if (cmd == 4'b0001) last_ref = cyc;
          init_step++;
        end else if (cmd == 4'b0011) begin
          chk(cke_prev, "R10 CKE high before activate", cke_prev, 1);
          chk(cyc - last_act >= TRC && cyc - last_ref >= TRC, "R3 activate spacing", cyc - last_act, TRC);
          chk(cyc >= bank_free, "R3 bank closed before activate", cyc, bank_free);
          chk(acc_q.size() > 0, "R9 activate for accepted request", acc_q.size(), 1);
          if (acc_q.size() > 0) begin
            r = acc_q[0];
            chk(sd_ba == 2'(r.bank) && sd_addr == 13'(r.row), "R4 activate bank/row", {sd_ba, sd_addr}, {2'(r.bank), 13'(r.row)});
          end
          last_act = cyc; act_cyc = cyc; open_row = 1;
        end else if (cmd == 4'b0100 || cmd == 4'b0101) begin
          chk(open_row && cyc - act_cyc >= TRCD, "R2 column after tRCD", cyc - act_cyc, TRCD);
          chk(sd_addr[10], "R4 auto-precharge bit", sd_addr[10], 1);
          if (acc_q.size() > 0) begin
            r = acc_q.pop_front();
            k = key_of(r.bank, r.row, r.col);
            chk(sd_ba == 2'(r.bank) && sd_addr[8:0] == 9'(r.col) && (cmd == 4'b0100) == r.we,
                "R4 column command matches request", {cmd, sd_ba, sd_addr[8:0]}, {r.we, 2'(r.bank), 9'(r.col)});
            if (cmd == 4'b0100) begin
              chk(sd_dq_oe && sd_dq_out == r.data, "R5 write data driven", sd_dq_out, r.data);
              chk(sd_dqm == ~r.be, "R5 write mask", sd_dqm, ~r.be);
              chk(dqm_h1 == '1 && dqm_h2 == '1 && dqm_h3 == '1, "R6 mask lead before write",
                  {dqm_h3, dqm_h2, dqm_h1}, 12'hFFF);
              rd_word = word_at(k);
              for (int b = 0; b < 4; b++) if (!sd_dqm[b]) rd_word[8*b +: 8] = sd_dq_out[8*b +: 8];
              mem[k] = rd_word;
              ps = (act_cyc + TRAS > cyc + TWR) ? act_cyc + TRAS : cyc + TWR;
            end else begin
              chk(!sd_dq_oe, "R5 no drive on read", sd_dq_oe, 0);
              rd_word = word_at(k);
              last_rd = cyc;
              ps = (act_cyc + TRAS > cyc + 1) ? act_cyc + TRAS : cyc + 1;
            end
            bank_free = ps + TRP;
          end
          open_row = 0;
        end else if (cmd == 4'b0001) begin
          chk(cke_prev, "R10 CKE high before refresh", cke_prev, 1);
          chk(cyc >= bank_free && cyc - last_act >= TRC && cyc - last_ref >= TRC, "R3 refresh spacing", cyc, bank_free);
          chk(cyc - last_ref <= REF_LIMIT, "R8 refresh gap", cyc - last_ref, REF_LIMIT);
          last_ref = cyc; refs_after++;
          if (bank_free < cyc + TRC) bank_free = cyc + TRC;
        end else if (cmd != 4'b0111) begin
          chk(0, "R4 unexpected command", cmd, 4'b0111);
        end
      end
      if (init_step < 4) chk(!req_ready, "R1 ready low during init", req_ready, 0);
      else chk(cyc - last_ref <= REF_LIMIT, "R8 refresh budget", cyc - last_ref, REF_LIMIT);
      if (cmd == 4'b0100 && sd_cke) exp_dqm = sd_dqm;
      else if (cyc == last_rd + CL - 2) exp_dqm = 4'h0;
      else exp_dqm = 4'hF;
      if (!(cmd == 4'b0100 && sd_cke)) chk(sd_dqm == exp_dqm, "R6 mask level", sd_dqm, exp_dqm);
      chk(rd_valid == (cyc == last_rd + CL + 1), "R7 read strobe timing", rd_valid, cyc == last_rd + CL + 1);
      if (rd_valid && cyc == last_rd + CL + 1) begin
        reads_seen++;
        chk(rd_data == rd_word, "R7 read data", rd_data, rd_word);
      end
      sd_dq_in = (cyc == last_rd + CL) ? rd_word : 32'hDEADBEEF;
      dqm_h3 = dqm_h2; dqm_h2 = dqm_h1; dqm_h1 = sd_dqm;
      cke_prev = sd_cke;
    end
  end

  task automatic send(input bit we, input int b, input int r, input int c,
                      input logic [31:0] d, input logic [3:0] be);
    req_s q;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_bank = 2'(b); req_row = 12'(r);
    req_col = 9'(c); req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    q.we = we; q.bank = b; q.row = r; q.col = c; q.data = d; q.be = be;
    acc_q.push_back(q);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!req_ready && sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111,
        "R1 reset state", {req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 6'b010111);
    chk(sd_dqm == 4'hF && !rd_valid && !sd_dq_oe, "R6 reset mask", sd_dqm, 4'hF);
    rst_n = 1'b1; rel_cyc = cyc;
    send(1, 0, 5, 3, 32'h11223344, 4'hF);
    send(0, 0, 5, 3, 0, 0);
    send(1, 1, 7, 9, 32'hAABBCCDD, 4'b0101);
    send(0, 1, 7, 9, 0, 0);
    send(1, 2, 100, 511, 32'hCAFEF00D, 4'b0000);   // R5 nothing written
    send(0, 2, 100, 511, 0, 0);
    send(1, 3, 4095, 0, 32'h99000000, 4'b1000);
    send(0, 3, 4095, 0, 0, 0);
    send(0, 1, 8, 1, 0, 0);
    pd_en = 1'b1;                                     // R10 power-down while idle
    repeat (60) @(negedge clk);
    send(0, 0, 5, 3, 0, 0);
    repeat (700) @(negedge clk);                      // R8 refresh from power-down
    pd_en = 1'b0;
    for (int i = 0; i < 60; i++)
      send(i % 2 == 0, (i / 2) % 4, 10 + i / 2, i * 7 % 512, 32'h01010101 * (i + 1), 4'(i + 3));
    repeat (40) @(negedge clk);
    chk(acc_q.size() == 0, "R9 all requests executed", acc_q.size(), 0);
    chk(pd_cycles > 0, "R10 power-down entered", pd_cycles, 1);
    chk(refs_after >= 3, "R8 periodic refreshes seen", refs_after, 3);
    chk(reads_seen == 36, "R7 read count", reads_seen, 36);
    finish_run();
  end
endmodule